// File: doc/BRIEF.md
# Background Memory CRC Integrity Checker

This block keeps watch over a region of memory that should never change. Once started, it reads the region one word at a time through a synchronous read port. It folds every word into a 32-bit CRC. At the end of each pass it folds in a stored reference value. An intact region leaves a zero remainder. Any other remainder raises the error output, and that output keeps the result of the most recent finished pass until the next pass ends.

The reference value sits in a 32-bit holding register. That register is loaded once when checking starts. While passes keep running, a test controller can shift a new value into it serially, so an error can be injected on purpose. A capture control reloads the register from the load input. A power-of-two divisor slows the reading rate. The divisor takes effect only at pass boundaries.

Top module: `mem_crc_scrubber`

## Requirements
- R1: After reset, no reads are issued and `crc_err_o` is 0. A `start_i` pulse loads the holding register from `ref_init_i` and starts passes. Any later `start_i` pulse has no effect until reset.
- R2: Each pass reads addresses 0 to DEPTH-1 in ascending order, one read per divider tick. Passes follow each other without a gap until reset. Read data is taken on the clock after `mem_rd_en_o`.
- R3: The CRC uses polynomial 0x04C11DB7, a zero initial state and no final inversion. Each word is processed most significant bit first. The pass remainder is the CRC of the words followed by the reference word. It is zero exactly when the reference equals the CRC of the words alone.
- R4: `crc_err_o` changes only two clocks after the read of address DEPTH-1 is issued. It then shows whether that pass's remainder is non-zero, and holds that value for the whole of the next pass.
- R5: A clean pass after a failed one returns `crc_err_o` to 0. No earlier failure is remembered.
- R6: The reference used by a pass is sampled when its first word is folded in. A change to the holding register made later in that pass affects only later passes.
- R7: While `scan_shift_i` is 1, the holding register shifts toward bit 0 once per clock. `scan_in_i` enters at bit 31 and `scan_out_o` shows bit 0. Reads continue during shifting. With no shift, capture or load, the register holds its value.
- R8: `scan_capture_i` reloads the holding register from `ref_init_i`. When shift and capture are both 1, shifting wins.
- R9: Reads are spaced 2^n clocks apart, where n is `div_exp_i`. A setting above 8 is treated as 8.
- R10: A new `div_exp_i` value is taken only when the read of address 0 is issued. The gap leading to address 0 still uses the old spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse that enters operating mode |
| ref_init_i | input | 32 | Precomputed reference for load and capture |
| div_exp_i | input | 4 | Divisor exponent n, spacing 2^n |
| mem_rd_en_o | output | 1 | Read strobe to the memory |
| mem_addr_o | output | AW | Word address of the read |
| mem_rd_data_i | input | 32 | Read data, valid the clock after the strobe |
| scan_shift_i | input | 1 | Shift the holding register serially |
| scan_capture_i | input | 1 | Reload the holding register from `ref_init_i` |
| scan_in_i | input | 1 | Serial data into bit 31 |
| scan_out_o | output | 1 | Serial data from bit 0 |
| crc_err_o | output | 1 | Remainder of the last finished pass is non-zero |

## Verification
The hardest case is showing that a fault appears exactly one pass late and no earlier. This applies both to a corrupted memory word and to a reference shifted in during a pass. The stimulus watches the read addresses on the ports. It flips a memory bit right after the last word of a pass has been read. It starts a 32-bit shift only after the first word of a pass has been fetched, with a divisor wide enough that the whole shift ends inside that pass. Each following pass end is then sampled on its exact clock.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  localparam int          WORD_W   = 32;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam int          EXP_W    = 4;
  localparam int          DIV_W    = 8;
  localparam logic [EXP_W-1:0] EXP_MAX = 4'd8;

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic { ST_IDLE, ST_RUN } run_t;

  // One 32-bit word folded into the CRC state, most significant bit first (R3)
  function automatic word_t crc_step(input word_t st, input word_t d);
    word_t c;
    logic  fb;
    c = st;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = c[WORD_W-1] ^ d[i];
      c  = {c[WORD_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  // Divisor exponent limited to the largest legal value (R9)
  function automatic logic [EXP_W-1:0] clamp_exp(input logic [EXP_W-1:0] n);
    return (n > EXP_MAX) ? EXP_MAX : n;
  endfunction

  // Countdown reload giving a tick every 2^n clocks
  function automatic logic [DIV_W-1:0] reload_of(input logic [EXP_W-1:0] n);
    logic [DIV_W:0] one;
    one = {{DIV_W{1'b0}}, 1'b1};
    return DIV_W'((one << n) - one);
  endfunction

endpackage

// File: rtl/mcs_tick_gen.sv
module mcs_tick_gen
  import mcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [EXP_W-1:0] div_sel_i,
  input  logic             boundary_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [EXP_W-1:0] exp_q;
  logic [EXP_W-1:0] exp_nxt;
  logic             apply;

  always_comb begin
    tick_o  = run_i && (cnt_q == '0);
    apply   = tick_o && boundary_i;                 // R10
    exp_nxt = apply ? clamp_exp(div_sel_i) : exp_q; // R9
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      exp_q <= exp_nxt;
      cnt_q <= reload_of(exp_nxt);
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/mcs_addr_seq.sv
module mcs_addr_seq #(
  parameter  int DEPTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  output logic          at_first_o,
  output logic          rd_en_o,
  output logic [AW-1:0] addr_o,
  output logic          first_o,
  output logic          last_o
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] cnt_q;

  assign at_first_o = (cnt_q == '0);

  // R2: ascending walk over the region, wrapping at the last word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rd_en_o <= 1'b0;
      addr_o  <= '0;
      first_o <= 1'b0;
      last_o  <= 1'b0;
    end else begin
      rd_en_o <= tick_i;
      if (tick_i) begin
        addr_o  <= cnt_q;
        first_o <= (cnt_q == '0);
        last_o  <= (cnt_q == LAST);
        cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mcs_ref_store.sv
module mcs_ref_store
  import mcs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  word_t ref_init_i,
  input  logic  shift_i,
  input  logic  capture_i,
  input  logic  scan_in_i,
  output logic  scan_out_o,
  output word_t store_o
);

  word_t store_q;

  // R1 load, R7 shift, R8 capture with shift first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         store_q <= '0;
    else if (load_i)    store_q <= ref_init_i;
    else if (shift_i)   store_q <= {scan_in_i, store_q[WORD_W-1:1]};
    else if (capture_i) store_q <= ref_init_i;
  end

  assign scan_out_o = store_q[0];
  assign store_o    = store_q;

endmodule

// File: rtl/mcs_crc_engine.sv
module mcs_crc_engine
  import mcs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_en_i,
  input  logic  rd_first_i,
  input  logic  rd_last_i,
  input  word_t data_i,
  input  word_t ref_i,
  output logic  err_o
);

  logic  vld_q, first_q, last_q;
  word_t state_q, seed_q, sig_q;
  word_t seed_now, folded;

  // Reference sampled with the first word of the pass (R6)
  assign seed_now = first_q ? ref_i : seed_q;
  assign folded   = crc_step(first_q ? '0 : state_q, data_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      state_q <= '0;
      seed_q  <= '0;
      sig_q   <= '0;
    end else begin
      vld_q   <= rd_en_i;
      first_q <= rd_en_i && rd_first_i;
      last_q  <= rd_en_i && rd_last_i;
      if (vld_q) begin
        seed_q <= seed_now;
        if (last_q) begin
          sig_q   <= crc_step(folded, seed_now); // R3, R4
          state_q <= '0;
        end else begin
          state_q <= folded;
        end
      end
    end
  end

  // R4, R5: flag follows the held signature only
  assign err_o = |sig_q;

endmodule

// File: rtl/mem_crc_scrubber.sv
module mem_crc_scrubber
  import mcs_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [31:0]   ref_init_i,
  input  logic [3:0]    div_exp_i,
  output logic          mem_rd_en_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [31:0]   mem_rd_data_i,
  input  logic          scan_shift_i,
  input  logic          scan_capture_i,
  input  logic          scan_in_i,
  output logic          scan_out_o,
  output logic          crc_err_o
);

  run_t  state_q;
  logic  run_active;
  logic  ref_load;
  logic  div_tick;
  logic  at_first;
  logic  rd_first;
  logic  rd_last;
  word_t ref_store;

  assign run_active = (state_q == ST_RUN);
  assign ref_load   = start_i && !run_active; // R1

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_IDLE;
    else if (ref_load) state_q <= ST_RUN;
  end

  mcs_tick_gen u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_active),
    .div_sel_i  (div_exp_i),
    .boundary_i (at_first),
    .tick_o     (div_tick)
  );

  mcs_addr_seq #(.DEPTH(DEPTH)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (div_tick),
    .at_first_o (at_first),
    .rd_en_o    (mem_rd_en_o),
    .addr_o     (mem_addr_o),
    .first_o    (rd_first),
    .last_o     (rd_last)
  );

  mcs_ref_store u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ref_load),
    .ref_init_i (ref_init_i),
    .shift_i    (scan_shift_i),
    .capture_i  (scan_capture_i),
    .scan_in_i  (scan_in_i),
    .scan_out_o (scan_out_o),
    .store_o    (ref_store)
  );

  mcs_crc_engine u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en_i    (mem_rd_en_o),
    .rd_first_i (rd_first),
    .rd_last_i  (rd_last),
    .data_i     (mem_rd_data_i),
    .ref_i      (ref_store),
    .err_o      (crc_err_o)
  );

endmodule

// File: rtl/mcs_checker.sv
module mcs_checker #(
  parameter  int DEPTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          mem_rd_en_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          scan_shift_i,
  input logic          scan_capture_i,
  input logic          scan_out_o,
  input logic          crc_err_o
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          started_q;
  logic          last_rd_q;
  logic [AW-1:0] exp_addr_q;
  logic [9:0]    gap_q, prev_gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q  <= 1'b0;
      last_rd_q  <= 1'b0;
      exp_addr_q <= '0;
      gap_q      <= '0;
      prev_gap_q <= '0;
    end else begin
      if (start_i) started_q <= 1'b1;
      last_rd_q <= mem_rd_en_o && (mem_addr_o == LAST);
      if (mem_rd_en_o) begin
        exp_addr_q <= (mem_addr_o == LAST) ? '0 : mem_addr_o + 1'b1;
        prev_gap_q <= gap_q;
        gap_q      <= 10'd1;
      end else if (gap_q != '0 && gap_q != 10'h3FF) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !started_q |-> (!mem_rd_en_o && !crc_err_o));

  // R2
  addr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en_o |-> (mem_addr_o == exp_addr_q));

  // R4
  err_change_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err_o != $past(crc_err_o)) |-> $past(last_rd_q));

  // R7
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_shift_i && !scan_capture_i && !start_i) |=> $stable(scan_out_o));

  // R9
  read_gap_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en_o && gap_q != '0) |-> (gap_q <= 10'd256 && $countones(gap_q) == 1));

  // R10
  read_gap_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en_o && mem_addr_o >= AW'(2) && prev_gap_q != '0) |-> (gap_q == prev_gap_q));

endmodule

bind mem_crc_scrubber mcs_checker #(.DEPTH(DEPTH)) u_mcs_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .mem_rd_en_o    (mem_rd_en_o),
  .mem_addr_o     (mem_addr_o),
  .scan_shift_i   (scan_shift_i),
  .scan_capture_i (scan_capture_i),
  .scan_out_o     (scan_out_o),
  .crc_err_o      (crc_err_o)
);

// File: tb/mem_crc_scrubber_bench.sv
`timescale 1ns/1ps
module mem_crc_scrubber_bench;

  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int LAST  = DEPTH - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [31:0]   ref_init_i = '0;
  logic [3:0]    div_exp_i = '0;
  logic          mem_rd_en_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0]   mem_rd_data_i = '0;
  logic          scan_shift_i = 1'b0;
  logic          scan_capture_i = 1'b0;
  logic          scan_in_i = 1'b0;
  logic          scan_out_o;
  logic          crc_err_o;

  logic [31:0] mem [DEPTH];
  logic [31:0] good_ref;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  mem_crc_scrubber #(.DEPTH(DEPTH)) u_mem_crc_scrubber (.*);

  always @(posedge clk) if (mem_rd_en_o) mem_rd_data_i <= mem[mem_addr_o];

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL R2 watchdog: cycles %0d expected below %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Long division of the bit stream (words, then 32 zeros) by the polynomial
  function automatic logic [31:0] region_crc();
    logic [31:0] r = '0;
    logic msb;
    for (int w = 0; w < DEPTH; w++)
      for (int b = 31; b >= 0; b--) begin
        msb = r[31];
        r = {r[30:0], mem[w][b]};
        if (msb) r = r ^ 32'h04C11DB7;
      end
    for (int z = 0; z < 32; z++) begin
      msb = r[31];
      r = {r[30:0], 1'b0};
      if (msb) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_rd(input int a);
    do @(negedge clk); while (!(mem_rd_en_o && int'(mem_addr_o) == a));
  endtask

  task automatic pass_result(input logic exp_err, input string req);
    wait_rd(LAST);
    @(negedge clk);
    @(negedge clk);
    chk(req, 32'(crc_err_o), 32'(exp_err));
  endtask

  task automatic gap_to(input int a, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!(mem_rd_en_o && int'(mem_addr_o) == a));
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk("R1 idle read strobe", 32'(mem_rd_en_o), 0);
    chk("R1 idle error flag", 32'(crc_err_o), 0);
  endtask

  task automatic t_start();
    ref_init_i = good_ref;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      do @(negedge clk); while (!mem_rd_en_o);
      chk("R2 read order", 32'(mem_addr_o), 32'(k));
    end
    @(negedge clk);
    @(negedge clk);
    chk("R3 clean pass remainder zero", 32'(crc_err_o), 0);
    pass_result(1'b0, "R2 back to back pass clean");
  endtask

  task automatic t_restart_ignored();
    ref_init_i = ~good_ref;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    ref_init_i = good_ref;
    wait_rd(0);
    pass_result(1'b0, "R1 second start ignored");
  endtask

  task automatic t_mem_flip();
    wait_rd(LAST);
    mem[DEPTH-2] = mem[DEPTH-2] ^ 32'h0000_0020;
    wait_rd(LAST);
    @(negedge clk);
    chk("R4 flag held until pass end", 32'(crc_err_o), 0);
    @(negedge clk);
    chk("R4 corrupt pass raises flag", 32'(crc_err_o), 1);
    mem[DEPTH-2] = mem[DEPTH-2] ^ 32'h0000_0020;
    wait_rd(DEPTH / 2);
    chk("R4 flag held through next pass", 32'(crc_err_o), 1);
    pass_result(1'b0, "R5 clean pass clears flag");
  endtask

  task automatic t_scan_inject();
    logic [31:0] bad, got;
    int reads = 0;
    bad = good_ref ^ 32'h8000_0001;
    div_exp_i = 4'd2;
    wait_rd(0);
    wait_rd(1);
    for (int i = 0; i < 32; i++) begin
      got[i] = scan_out_o;
      scan_in_i = bad[i];
      scan_shift_i = 1'b1;
      if (mem_rd_en_o) reads++;
      @(negedge clk);
    end
    scan_shift_i = 1'b0;
    chk("R7 shifted out reference", got, good_ref);
    chk("R7 reads continue while shifting", 32'(reads > 0), 1);
    pass_result(1'b0, "R6 current pass keeps sampled reference");
    pass_result(1'b1, "R3 wrong reference gives non-zero remainder");
  endtask

  task automatic t_capture();
    logic [31:0] got;
    scan_capture_i = 1'b1;
    @(negedge clk);
    scan_capture_i = 1'b0;
    wait_rd(0);
    pass_result(1'b0, "R8 capture restores reference");
    scan_shift_i = 1'b1;
    scan_capture_i = 1'b1;
    scan_in_i = 1'b1;
    @(negedge clk);
    scan_capture_i = 1'b0;
    scan_in_i = 1'b0;
    for (int i = 0; i < 32; i++) begin
      got[i] = scan_out_o;
      @(negedge clk);
    end
    scan_shift_i = 1'b0;
    chk("R8 shift wins over capture", got, {1'b1, good_ref[31:1]});
    scan_capture_i = 1'b1;
    @(negedge clk);
    scan_capture_i = 1'b0;
    wait_rd(0);
    pass_result(1'b0, "R8 capture after shift");
  endtask

  task automatic t_divisor();
    int g;
    wait_rd(5);
    div_exp_i = 4'd12;
    wait_rd(LAST);
    gap_to(0, g);
    chk("R10 gap into address 0 keeps old divisor", 32'(g), 4);
    gap_to(1, g);
    chk("R9 setting above 8 clamped to 256", 32'(g), 256);
    div_exp_i = 4'd3;
    gap_to(2, g);
    chk("R10 mid-pass setting not applied", 32'(g), 256);
    wait_rd(0);
    gap_to(1, g);
    chk("R9 divisor 2^3", 32'(g), 8);
    @(negedge clk);
    chk("R5 flag still clear", 32'(crc_err_o), 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = (32'h9E3779B9 * (i + 1)) ^ (i << 7);
    good_ref = region_crc();
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_start();
    t_restart_ignored();
    t_mem_flip();
    t_scan_inject();
    t_capture();
    t_divisor();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule